// File: doc/BRIEF.md
# Strobe-Multiplexed Supercell Memory with Access Sequencer

This block models a small dynamic memory, 16 cells of one byte each laid out as four rows of four columns, together with the sequencer that reaches it. The memory sees only a narrow two-bit address bus and two strobes. A row strobe cycle carries a row number and copies that entire row into an internal row buffer. A later column strobe cycle carries a column number and acts only on that buffer. It either returns one byte from the buffer, or merges a new byte into the buffer and writes the whole row back to the array.

A host issues one request at a time through a simple port: a valid flag, a write flag, a four-bit cell address and a write byte. The address is split as {row, column}, with the row in the upper two bits. The sequencer steps through idle, row strobe, column strobe and completion, one cycle each. It raises a single-cycle completion pulse, and read data is valid during that pulse. The strobes and the shared address bus are brought out so that the order of the two phases can be observed.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After synchronous reset, req_ready is 1 and rsp_done, dram_ras and dram_cas are 0.
- R2: When req_valid is high while req_ready is high, the request is accepted. In the next cycle dram_ras is 1, dram_cas is 0 and dram_addr equals req_addr[3:2] (the row).
- R3: The cycle after the row strobe, dram_cas is 1, dram_ras is 0 and dram_addr equals req_addr[1:0] (the column). The column strobe is never issued unless the row strobe was high in the cycle before.
- R4: rsp_done is high for exactly one cycle, the cycle after the column strobe, which is three cycles after acceptance. req_ready returns to 1 in the cycle after rsp_done.
- R5: For a read (req_we=0), rsp_rdata during rsp_done equals the byte last written to the addressed cell. rsp_rdata keeps that value until the next read completes, including across idle cycles and writes.
- R6: A write (req_we=1) stores req_wdata into the addressed cell only. The other three cells of the same row keep their values.
- R7: req_ready is 0 from the row strobe cycle through the rsp_done cycle. A request presented in that window is ignored and does not change any cell.
- R8: Cell address a maps to row a[3:2] and column a[1:0]. All 16 cells hold independent values.
- R9: A read issued immediately after a write to the same row returns the new byte, because the row is written back before the write's rsp_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Cell address {row[1:0], col[1:0]} |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_done |
| dram_ras | output | 1 | Row strobe on the memory side |
| dram_cas | output | 1 | Column strobe on the memory side |
| dram_addr | output | 2 | Shared row/column address bus |

## Verification
The hardest case to reach from the ports is a request that arrives while the sequencer is busy. Such a request must leave every cell untouched, including one in the row currently latched in the buffer. The bench holds req_valid high through the strobe and completion cycles with a conflicting write. It then reads the targeted cell back to confirm that nothing changed. The partial-row write-back is covered in a similar way. Each column of a row is filled with a distinct byte, one column is overwritten, and every neighbour is read back, including a read issued in the very next idle cycle.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAS  = 2'd1,
    ST_CAS  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;
endpackage

// File: rtl/dram_mux_array.sv
// Cell array with a whole-row registered read port that doubles as the
// row buffer, and a whole-row write-back port.
module dram_mux_array #(
  parameter int ROW_BITS = 2,
  parameter int ROW_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ras_i,
  input  logic [ROW_BITS-1:0] row_i,
  input  logic                wb_en_i,
  input  logic [ROW_W-1:0]    wb_row_i,
  output logic [ROW_W-1:0]    row_buf_o
);
  localparam int ROWS = 1 << ROW_BITS;

  logic [ROW_W-1:0]    mem [ROWS];
  logic [ROW_W-1:0]    buf_q;
  logic [ROW_BITS-1:0] open_row_q;

  // Memory and its output register: no reset so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (wb_en_i) begin
      mem[open_row_q] <= wb_row_i;
      buf_q           <= wb_row_i;
    end else if (ras_i) begin
      buf_q <= mem[row_i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        open_row_q <= '0;
    else if (ras_i) open_row_q <= row_i;
  end

  assign row_buf_o = buf_q;
endmodule

// File: rtl/dram_mux_colpath.sv
// Column stage: selects one cell out of the row buffer for reads and
// builds the merged row for write-back.
module dram_mux_colpath #(
  parameter int COL_BITS = 2,
  parameter int DATA_W   = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cas_i,
  input  logic                             we_i,
  input  logic [COL_BITS-1:0]              col_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [(DATA_W<<COL_BITS)-1:0]    row_buf_i,
  output logic                             wb_en_o,
  output logic [(DATA_W<<COL_BITS)-1:0]    wb_row_o,
  output logic [DATA_W-1:0]                rdata_o
);
  localparam int COLS = 1 << COL_BITS;

  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] sel_cell;

  for (genvar c = 0; c < COLS; c++) begin : g_merge
    assign wb_row_o[c*DATA_W +: DATA_W] =
      (col_i == COL_BITS'(c)) ? wdata_i : row_buf_i[c*DATA_W +: DATA_W];
  end

  assign sel_cell = row_buf_i[col_i*DATA_W +: DATA_W];
  assign wb_en_o  = cas_i && we_i;

  always_ff @(posedge clk) begin
    if (rst)                 rdata_q <= '0;
    else if (cas_i && !we_i) rdata_q <= sel_cell;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dram_mux_seq.sv
// Access sequencer: idle -> row strobe -> column strobe -> done.
module dram_mux_seq
  import dram_mux_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = ROW_BITS + COL_BITS,
  localparam int BUS_W   = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic              ras_o,
  output logic              cas_o,
  output logic [BUS_W-1:0]  abus_o,
  output logic              done_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);
  seq_state_t          state_q;
  logic                ras_q, cas_q, done_q, we_q;
  logic [BUS_W-1:0]    abus_q;
  logic [COL_BITS-1:0] col_q;
  logic [DATA_W-1:0]   wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ras_q   <= 1'b0;
      cas_q   <= 1'b0;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      abus_q  <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            state_q <= ST_RAS;
            ras_q   <= 1'b1;
            abus_q  <= BUS_W'(req_addr_i[ADDR_W-1 -: ROW_BITS]);
            col_q   <= req_addr_i[COL_BITS-1:0];
            we_q    <= req_we_i;
            wdata_q <= req_wdata_i;
          end
        end
        ST_RAS: begin
          state_q <= ST_CAS;
          ras_q   <= 1'b0;
          cas_q   <= 1'b1;
          abus_q  <= BUS_W'(col_q);
        end
        ST_CAS: begin
          state_q <= ST_DONE;
          cas_q   <= 1'b0;
          done_q  <= 1'b1;
        end
        default: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b0;
        end
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign ras_o   = ras_q;
  assign cas_o   = cas_q;
  assign abus_o  = abus_q;
  assign done_o  = done_q;
  assign we_o    = we_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = ROW_BITS + COL_BITS,
  localparam int BUS_W   = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS,
  localparam int ROW_W   = DATA_W << COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dram_ras,
  output logic              dram_cas,
  output logic [BUS_W-1:0]  dram_addr
);
  logic              seq_we;
  logic [DATA_W-1:0] seq_wdata;
  logic [ROW_W-1:0]  row_buf;
  logic [ROW_W-1:0]  wb_row;
  logic              wb_en;

  dram_mux_seq #(
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid_i(req_valid),
    .req_we_i   (req_we),
    .req_addr_i (req_addr),
    .req_wdata_i(req_wdata),
    .ready_o    (req_ready),
    .ras_o      (dram_ras),
    .cas_o      (dram_cas),
    .abus_o     (dram_addr),
    .done_o     (rsp_done),
    .we_o       (seq_we),
    .wdata_o    (seq_wdata)
  );

  dram_mux_array #(
    .ROW_BITS(ROW_BITS), .ROW_W(ROW_W)
  ) u_array (
    .clk      (clk),
    .rst      (rst),
    .ras_i    (dram_ras),
    .row_i    (dram_addr[ROW_BITS-1:0]),
    .wb_en_i  (wb_en),
    .wb_row_i (wb_row),
    .row_buf_o(row_buf)
  );

  dram_mux_colpath #(
    .COL_BITS(COL_BITS), .DATA_W(DATA_W)
  ) u_col (
    .clk      (clk),
    .rst      (rst),
    .cas_i    (dram_cas),
    .we_i     (seq_we),
    .col_i    (dram_addr[COL_BITS-1:0]),
    .wdata_i  (seq_wdata),
    .row_buf_i(row_buf),
    .wb_en_o  (wb_en),
    .wb_row_o (wb_row),
    .rdata_o  (rsp_rdata)
  );
endmodule

// File: rtl/dram_mux_chk.sv
module dram_mux_chk #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  localparam int ADDR_W  = ROW_BITS + COL_BITS,
  localparam int BUS_W   = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              dram_ras,
  input logic              dram_cas,
  input logic [BUS_W-1:0]  dram_addr
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (req_ready && !rsp_done && !dram_ras && !dram_cas));

  assert_accept_row_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=>
      (dram_ras && !dram_cas &&
       dram_addr == BUS_W'($past(req_addr[ADDR_W-1 -: ROW_BITS]))));

  assert_row_before_col_R3: assert property (@(posedge clk) disable iff (rst)
    dram_cas |-> $past(dram_ras));

  assert_col_then_done_R4: assert property (@(posedge clk) disable iff (rst)
    dram_cas |=> rsp_done);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  assert_phase_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dram_ras, dram_cas, rsp_done}));

  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (dram_ras || dram_cas || rsp_done) |-> !req_ready);
endmodule

bind dram_mux_ctrl dram_mux_chk #(
  .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_addr (req_addr),
  .req_ready(req_ready),
  .rsp_done (rsp_done),
  .dram_ras (dram_ras),
  .dram_cas (dram_cas),
  .dram_addr(dram_addr)
);

// File: tb/dram_mux_ctrl_test.sv
`timescale 1ns/1ps
module dram_mux_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_we = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_done, dram_ras, dram_cas;
  logic [7:0] rsp_rdata;
  logic [1:0] dram_addr;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0] model [16];

  always #10 clk = ~clk;

  dram_mux_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .dram_ras(dram_ras),
    .dram_cas(dram_cas), .dram_addr(dram_addr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One access; returns read byte and cycles from acceptance to done.
  task automatic access(input bit we, input logic [3:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    if (we) model[a] = d;
  endtask

  task automatic test_reset;
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(rsp_done == 1'b0, "R1 done", rsp_done, 0);
    check(dram_ras == 1'b0, "R1 ras", dram_ras, 0);
    check(dram_cas == 1'b0, "R1 cas", dram_cas, 0);
  endtask

  task automatic test_phases;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 4'b1001; req_wdata = 8'h00;
    @(negedge clk);   // row strobe cycle
    req_valid = 1'b0;
    check(dram_ras == 1'b1 && dram_cas == 1'b0, "R2 ras phase", {dram_ras, dram_cas}, 2'b10);
    check(dram_addr == 2'b10, "R2 row on bus", dram_addr, 2'b10);
    check(req_ready == 1'b0, "R7 busy in ras", req_ready, 0);
    @(negedge clk);   // column strobe cycle
    check(dram_cas == 1'b1 && dram_ras == 1'b0, "R3 cas phase", {dram_ras, dram_cas}, 2'b01);
    check(dram_addr == 2'b01, "R3 col on bus", dram_addr, 2'b01);
    @(negedge clk);   // done cycle
    check(rsp_done == 1'b1, "R4 done", rsp_done, 1);
    check(req_ready == 1'b0, "R7 busy in done", req_ready, 0);
    @(negedge clk);
    check(rsp_done == 1'b0, "R4 done one cycle", rsp_done, 0);
    check(req_ready == 1'b1, "R4 ready back", req_ready, 1);
  endtask

  task automatic test_fill_and_read;
    logic [7:0] rd;
    int lat;
    for (int a = 0; a < 16; a++)
      access(1'b1, 4'(a), 8'(8'h30 + a * 7), rd, lat);
    for (int a = 0; a < 16; a++) begin
      access(1'b0, 4'(a), 8'hFF, rd, lat);
      check(rd == model[a], "R8 R5 cell readback", rd, model[a]);
      if (a == 0) check(lat == 3, "R4 latency", lat, 3);
    end
  endtask

  task automatic test_partial_row;
    logic [7:0] rd;
    int lat;
    access(1'b1, 4'b0110, 8'hA5, rd, lat);
    access(1'b0, 4'b0110, 8'h00, rd, lat);
    check(rd == 8'hA5, "R9 read after write", rd, 8'hA5);
    for (int c = 0; c < 4; c++) begin
      access(1'b0, {2'b01, 2'(c)}, 8'h00, rd, lat);
      check(rd == model[{2'b01, 2'(c)}], "R6 row neighbours", rd, model[{2'b01, 2'(c)}]);
    end
  endtask

  task automatic test_hold;
    logic [7:0] rd;
    int lat;
    access(1'b0, 4'b1111, 8'h00, rd, lat);
    repeat (3) @(negedge clk);
    check(rsp_rdata == model[15], "R5 hold idle", rsp_rdata, model[15]);
    access(1'b1, 4'b0000, 8'h5C, rd, lat);
    check(rsp_rdata == model[15], "R5 hold across write", rsp_rdata, model[15]);
  endtask

  task automatic test_busy_ignore;
    logic [7:0] rd;
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 4'b1101; req_wdata = 8'h00;
    @(negedge clk);   // ras: present a conflicting write
    req_we = 1'b1; req_addr = 4'b1110; req_wdata = 8'hEE;
    @(negedge clk);   // cas
    @(negedge clk);   // done
    check(rsp_done == 1'b1, "R7 original completes", rsp_done, 1);
    check(rsp_rdata == model[13], "R7 original data", rsp_rdata, model[13]);
    req_valid = 1'b0; req_we = 1'b0;
    @(negedge clk);
    check(dram_ras == 1'b0, "R7 no extra access", dram_ras, 0);
    access(1'b0, 4'b1110, 8'h00, rd, lat);
    check(rd == model[14], "R7 cell untouched", rd, model[14]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_phases();
    test_fill_and_read();
    test_partial_row();
    test_hold();
    test_busy_ignore();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule